// File: doc/BRIEF.md
# Accumulator Result Normalizer

This block turns a wide signed accumulator result into a narrow signed output sample. A programmable window picks which 16 consecutive bits of the 40-bit result become the output. The window is named by the index of its least significant bit. Bits below the window are either dropped (truncation toward minus infinity) or first rounded by adding half of the window's LSB weight. When the discarded upper bits do not all match the sign, the output clamps to the largest positive or largest negative 16-bit code.

The block sits after a multiply-accumulate datapath. Each result is presented with a valid strobe and appears, normalized, one clock later. The window code and the rounding flag are static configuration that is sampled together with each valid result.

Top module: `result_normalizer`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier.
- R2: While `rst_n` is low, `out_valid` is 0 and `out_data` is 16'h0000.
- R3: With `round_en` = 0 and window LSB index p, the output is floor(in_data / 2^p), where in_data is read as two's complement, whenever that value lies in [-32768, 32767].
- R4: With `round_en` = 1 and p > 0, the value 2^(p-1) is added to the full-width input before the window is taken, so halves round toward plus infinity.
- R5: With p = 0, `round_en` has no effect on the output.
- R6: Window codes 25 to 31 behave exactly like code 24.
- R7: When the windowed value, after any rounding, exceeds 32767, the output is 16'h7FFF. This includes a carry out of the rounding addition.
- R8: When the windowed value is below -32768, the output is 16'h8000.
- R9: While `in_valid` is 0, `out_data` keeps its last value, whatever `in_data`, `win_pos` and `round_en` do.
- R10: A non-negative input never yields a negative output. A negative input with `round_en` = 0 always yields a negative output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input result valid |
| in_data | input | 40 | Signed accumulator result |
| win_pos | input | 5 | Index of the output window's LSB (0..24, higher codes clamp) |
| round_en | input | 1 | 1: round by half window LSB; 0: truncate |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Normalized signed output sample |

## Verification
Every result of this block appears one clock edge after the inputs that produced it: the output register captures on the edge that follows the valid input. The bench drives inputs on the falling edge and reads `out_data` and `out_valid` on the next falling edge, half a clock after that capture. Hold behaviour is checked the same way. The bench drops `in_valid`, changes the other inputs, and samples one falling edge later, at the point where a wrongly enabled register would already show new data.

// File: rtl/norm_pkg.sv
package norm_pkg;
  parameter int NORM_ACC_W = 40;
  parameter int NORM_RES_W = 16;
  parameter int NORM_POS_W = 5;
endpackage

// File: rtl/norm_pos_clamp.sv
module norm_pos_clamp #(
  parameter int POS_W   = 5,
  parameter int MAX_POS = 24
) (
  input  logic [POS_W-1:0] pos_code,
  output logic [POS_W-1:0] pos_eff
);
  localparam logic [POS_W-1:0] LIMIT = POS_W'(MAX_POS);

  always_comb begin
    if (pos_code > LIMIT) pos_eff = LIMIT;
    else                  pos_eff = pos_code;
  end
endmodule

// File: rtl/norm_round_add.sv
module norm_round_add #(
  parameter int ACC_W = 40,
  parameter int POS_W = 5
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [POS_W-1:0] pos,
  input  logic             round_en,
  output logic [ACC_W:0]   sum
);
  localparam int SUM_W = ACC_W + 1;

  logic [SUM_W-1:0] acc_ext;
  logic [SUM_W-1:0] unit;
  logic [SUM_W-1:0] half;

  always_comb begin
    acc_ext = {acc[ACC_W-1], acc};
    unit    = SUM_W'(1) << pos;
    // half of the window LSB; zero when the window starts at bit 0
    half    = round_en ? (unit >> 1) : '0;
    sum     = acc_ext + half;
  end
endmodule

// File: rtl/norm_window_sat.sv
module norm_window_sat #(
  parameter int ACC_W = 40,
  parameter int RES_W = 16,
  parameter int POS_W = 5
) (
  input  logic [ACC_W:0]   sum,
  input  logic [POS_W-1:0] pos,
  output logic [RES_W-1:0] res
);
  localparam int SUM_W = ACC_W + 1;
  localparam int TOP_W = SUM_W - RES_W + 1;
  localparam logic [RES_W-1:0] POS_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG_MAX = {1'b1, {(RES_W-1){1'b0}}};

  logic [SUM_W-1:0] shifted;
  logic [TOP_W-1:0] upper;
  logic             fits;

  always_comb begin
    shifted = SUM_W'($signed(sum) >>> pos);
    upper   = shifted[SUM_W-1:RES_W-1];
    fits    = (&upper) | ~(|upper);
    if (fits)                res = shifted[RES_W-1:0];
    else if (sum[SUM_W-1])   res = NEG_MAX;
    else                     res = POS_MAX;
  end
endmodule

// File: rtl/result_normalizer.sv
module result_normalizer
  import norm_pkg::*;
#(
  parameter int ACC_W = NORM_ACC_W,
  parameter int RES_W = NORM_RES_W,
  parameter int POS_W = NORM_POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] in_data,
  input  logic [POS_W-1:0] win_pos,
  input  logic             round_en,
  output logic             out_valid,
  output logic [RES_W-1:0] out_data
);
  localparam int MAX_POS = ACC_W - RES_W;

  logic [POS_W-1:0] pos_eff;
  logic [ACC_W:0]   rnd_sum;
  logic [RES_W-1:0] norm_res;
  logic [RES_W-1:0] data_d;
  logic [RES_W-1:0] data_q;
  logic             vld_q;

  norm_pos_clamp #(.POS_W(POS_W), .MAX_POS(MAX_POS)) u_clamp (
    .pos_code (win_pos),
    .pos_eff  (pos_eff)
  );

  norm_round_add #(.ACC_W(ACC_W), .POS_W(POS_W)) u_round (
    .acc      (in_data),
    .pos      (pos_eff),
    .round_en (round_en),
    .sum      (rnd_sum)
  );

  norm_window_sat #(.ACC_W(ACC_W), .RES_W(RES_W), .POS_W(POS_W)) u_window (
    .sum (rnd_sum),
    .pos (pos_eff),
    .res (norm_res)
  );

  // next-state: load only on a valid result
  always_comb begin
    data_d = data_q;
    if (in_valid) data_d = norm_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= in_valid;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/norm_chk.sv
module norm_chk #(
  parameter int ACC_W = 40,
  parameter int RES_W = 16,
  parameter int POS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [ACC_W-1:0] in_data,
  input logic [POS_W-1:0] win_pos,
  input logic             round_en,
  input logic             out_valid,
  input logic [RES_W-1:0] out_data
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (out_valid == 1'b0 && out_data == '0);
    end
  end

  // R1
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !in_valid) |=> $stable(out_data));

  // R10
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && !in_data[ACC_W-1]) |=> !out_data[RES_W-1]);

  // R10
  neg_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && in_data[ACC_W-1] && !round_en) |=> out_data[RES_W-1]);

  // R3
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && in_data == '0) |=> (out_data == '0));
endmodule

bind result_normalizer norm_chk #(.ACC_W(ACC_W), .RES_W(RES_W), .POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .win_pos   (win_pos),
  .round_en  (round_en),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_result_normalizer.sv
`timescale 1ns/1ps
module sim_result_normalizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] in_data = '0;
  logic [4:0]  win_pos = '0;
  logic        round_en = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  result_normalizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .win_pos(win_pos), .round_en(round_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [15:0] model(input logic [39:0] d, input logic [4:0] p, input logic r);
    longint v;
    int     q;
    v = longint'($signed(d));
    q = (p > 5'd24) ? 24 : int'(p);
    if (r && q > 0) v = v + (longint'(1) <<< (q - 1));
    v = v >>> q;
    if (v > 32767)       return 16'h7FFF;
    else if (v < -32768) return 16'h8000;
    else                 return v[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, result sampled one falling edge later
  task automatic apply(input string req, input logic [39:0] d, input logic [4:0] p, input logic r);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; win_pos = p; round_en = r;
    @(negedge clk);
    check(req, out_data, model(d, p, r));
    check({req, " valid R1"}, {15'd0, out_valid}, 16'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R2 data", out_data, 16'h0000);
    check("R2 valid", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;

    // R3 plain window selections
    apply("R3 p0", 40'h00_0000_1234, 5'd0, 1'b0);
    apply("R3 p8", 40'h00_0012_3456, 5'd8, 1'b0);
    apply("R3 neg trunc", 40'hFF_FFFF_FFE8, 5'd4, 1'b0);   // -24/16 -> -2
    // R4 rounding at half
    apply("R4 pos half", 40'h00_0000_0018, 5'd4, 1'b1);    // 1.5 -> 2
    apply("R4 neg half", 40'hFF_FFFF_FFE8, 5'd4, 1'b1);    // -1.5 -> -1
    apply("R4 below half", 40'h00_0000_0017, 5'd4, 1'b1);  // -> 1
    // R5 p=0 rounding ignored
    apply("R5 p0 round", 40'h00_0000_7FFF, 5'd0, 1'b1);
    check("R5 value", out_data, 16'h7FFF);
    // R6 clamp codes
    apply("R6 code31", 40'h12_3456_789A, 5'd31, 1'b0);
    check("R6 eq24", out_data, 16'h1234);
    apply("R6 code25 round", 40'h7F_FFFF_FFFF, 5'd25, 1'b1);
    // R7 R8 saturation
    apply("R7 sat pos", 40'h7F_FFFF_FFFF, 5'd0, 1'b0);
    check("R7 code", out_data, 16'h7FFF);
    apply("R7 round carry", 40'h00_0007_FFF8, 5'd4, 1'b1);
    check("R7 carry code", out_data, 16'h7FFF);
    apply("R8 sat neg", 40'h80_0000_0000, 5'd8, 1'b0);
    check("R8 code", out_data, 16'h8000);

    // R9 hold while invalid
    apply("R9 setup", 40'h00_0000_0ABC, 5'd0, 1'b0);
    held = out_data;
    @(negedge clk);
    in_valid = 1'b0; in_data = 40'h55_5555_5555; win_pos = 5'd3; round_en = 1'b1;
    @(negedge clk);
    check("R9 hold", out_data, held);
    check("R1 low", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R9 hold2", out_data, held);

    // random mix covering R3 R4 R7 R8 R10
    for (int i = 0; i < 300; i++) begin
      logic [39:0] d;
      logic [4:0]  p;
      int          sh;
      d  = {$urandom(), $urandom()};
      sh = $urandom_range(0, 30);
      d  = 40'($signed(d) >>> sh);
      p  = 5'($urandom_range(0, 31));
      apply("R3/R4/R7/R8 random", d, p, 1'($urandom_range(0, 1)));
    end

    @(negedge clk);
    in_valid = 1'b0;
    finish_run();
  end
endmodule